// File: doc/BRIEF.md
# Folded Path History Compressor

This block keeps a speculative global path history as a circular buffer of single bits and maintains, for each predictor table, three short registers that hold a compressed form of the most recent history. Each register has its own history length L and compressed width W. A predictor front end reads these registers when it forms table indices and partial tags. Every branch that the front end reports contributes ten history bits.

For a conditional branch, the ten bits are the taken flag followed by nine zeros. For any other branch, they are the low ten bits of a hash of the branch PC and its target. A small sequencer pushes the ten bits one per clock cycle. On each push, every compressed register is updated incrementally: it absorbs the new bit and cancels the bit that has just aged past its length L. The compressed values are visible on output buses at all times.

Branch records enter through a valid/ready interface. The block takes a record on any rising edge where `br_valid` and `br_ready` are both high. After that it holds `br_ready` low, and `busy` high, for exactly ten cycles. While `br_ready` is low, the contents of `br_valid` and the data inputs have no effect. A producer may keep its data on the inputs until it sees `br_ready` again.

Top module: `path_hist_folder`

## Requirements
- R1: After a synchronous reset, every compressed register reads zero, `busy` is low and `br_ready` is high. The history holds only zeros.
- R2: A record is taken on a rising edge with `br_valid` and `br_ready` both high. `busy` is then high and `br_ready` low for exactly 10 cycles. Records and input changes offered during that time are ignored.
- R3: For a branch with `br_cond` low, the bits inserted are bits 0 to 9 of (target XOR (target >> 3) XOR PC), bit 0 first.
- R4: For a branch with `br_cond` high, the bits inserted are `br_taken` first and then nine zeros.
- R5: Table t has an index register of width IDX_W[t]. Take the history bits newest first as b0, b1, and so on. Once a record's tenth bit is in, this register equals the XOR over k < HLEN[t] of b_k placed at bit position (k mod IDX_W[t]).
- R6: The two tag registers of table t follow the same rule with widths TAG_W[t] and TAG_W[t]-1.
- R7: History bits older than HLEN[t] positions have no effect on any register of table t.
- R8: The buffer pointer decrements by one on every inserted bit and wraps modulo 2^BUF_LOG2. The compressed values stay correct after the pointer has wrapped.
- R9: While the block is idle, all compressed registers and the buffer pointer hold their values.
- R10: Each output bus packs table t into bits [t*MAXW +: MAXW], zero-extended. MAXW is the largest index or tag width; it is 13 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_valid | input | 1 | Branch record offered |
| br_ready | output | 1 | Block can take a record (idle) |
| br_pc | input | AW (32) | Branch PC |
| br_tgt | input | AW (32) | Branch target |
| br_taken | input | 1 | Taken flag, used for conditional branches |
| br_cond | input | 1 | Record is a conditional branch |
| busy | output | 1 | Sequencer is inserting bits |
| fold_idx | output | NT*MAXW (52) | Index-width compressed values, per table |
| fold_tag | output | NT*MAXW (52) | Tag-width compressed values, per table |
| fold_tagm | output | NT*MAXW (52) | Compressed values of tag width minus one, per table |

## Verification
Suppose a record is taken on rising edge E0. The ten bits are inserted on edges E1 through E10. `busy` drops and every compressed value reaches its final value on E10. The monitor samples on falling edges, and it compares against the scoreboard only on the falling edge where `busy` is first seen low after being high; this is the one following E10. It also counts the falling edges on which `busy` was high and expects exactly ten. The bench checks that values are held while idle by sampling again several cycles after a record has finished, before the next record is offered.

// File: rtl/phc_pkg.sv
package phc_pkg;

  localparam int PATH_BITS = 10;
  localparam int STEP_CW   = $clog2(PATH_BITS + 1);

  typedef logic [PATH_BITS-1:0] path_t;

  // Bits pushed into the history for one branch record.
  function automatic path_t make_path(input logic [63:0] pc,
                                      input logic [63:0] tgt,
                                      input logic        taken,
                                      input logic        cond);
    logic [63:0] mix;
    path_t       p;
    mix = tgt ^ (tgt >> 3) ^ pc;
    if (cond) p = {{(PATH_BITS-1){1'b0}}, taken};
    else      p = mix[PATH_BITS-1:0];
    return p;
  endfunction

endpackage

// File: rtl/phc_path_seq.sv
module phc_path_seq
  import phc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] tgt,
  input  logic          taken,
  input  logic          cond,
  output logic          busy,
  output logic          step,
  output logic          step_bit
);

  localparam logic [STEP_CW-1:0] LAST = STEP_CW'(PATH_BITS - 1);

  logic [STEP_CW-1:0] cnt;
  path_t              shreg;
  logic               accept;

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;
  assign step     = busy;
  assign step_bit = shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= '0;
      shreg <= make_path(64'(pc), 64'(tgt), taken, cond);
    end else if (busy) begin
      shreg <= shreg >> 1;
      cnt   <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (busy && cnt == '0)) else $error("accept"); // R2

  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == LAST) |=> !busy) else $error("run length"); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST)) else $error("count bound"); // R2

  AST_COND_PATH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && cond) |=>
      (shreg[PATH_BITS-1:1] == '0 && shreg[0] == $past(taken))) else $error("cond path"); // R4

endmodule

// File: rtl/phc_hist_buf.sv
module phc_hist_buf #(
  parameter int BUF_LOG2 = 10,
  parameter int NT       = 4,
  parameter int HLEN [NT] = '{10, 27, 60, 219}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          new_bit,
  output logic [NT-1:0] aged_o
);

  localparam int DEPTH = 1 << BUF_LOG2;

  logic [DEPTH-1:0]    hbuf;
  logic [BUF_LOG2-1:0] ptr;
  logic [BUF_LOG2-1:0] ptr_nx;

  assign ptr_nx = ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hbuf <= '0;
      ptr  <= '0;
    end else if (step) begin
      ptr          <= ptr_nx;
      hbuf[ptr_nx] <= new_bit;
    end
  end

  // The bit that leaves the window of length HLEN[t] on this step.
  for (genvar t = 0; t < NT; t++) begin : g_age
    localparam logic [BUF_LOG2-1:0] OFF = BUF_LOG2'(HLEN[t]);
    logic [BUF_LOG2-1:0] rd;
    assign rd        = ptr_nx + OFF;
    assign aged_o[t] = hbuf[rd];
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> (ptr == $past(ptr) - 1'b1)) else $error("ptr step"); // R8

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ptr)) else $error("ptr hold"); // R9

  AST_BIT_STORED: assert property (@(posedge clk) disable iff (rst)
    step |=> (hbuf[ptr] == $past(new_bit))) else $error("bit stored"); // R3

endmodule

// File: rtl/phc_fold_reg.sv
module phc_fold_reg #(
  parameter int L    = 10,
  parameter int W    = 8,
  parameter int MAXW = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            new_bit,
  input  logic            aged_bit,
  output logic [MAXW-1:0] val_o
);

  localparam int OUTPT = L % W;

  logic [W-1:0] comp;
  logic [W:0]   sh;
  logic [W-1:0] nxt;

  always_comb begin
    sh        = {comp, new_bit};
    sh[OUTPT] = sh[OUTPT] ^ aged_bit;
    nxt       = sh[W-1:0];
    nxt[0]    = nxt[0] ^ sh[W];
  end

  always_ff @(posedge clk) begin
    if (rst)       comp <= '0;
    else if (step) comp <= nxt;
  end

  if (MAXW > W) begin : g_pad
    assign val_o = {{(MAXW-W){1'b0}}, comp};
  end else begin : g_nopad
    assign val_o = comp;
  end

  AST_FOLD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(comp)) else $error("fold hold"); // R9

  AST_FOLD_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (step && !new_bit && !aged_bit) |=>
      (comp == {$past(comp[W-2:0]), $past(comp[W-1])})) else $error("fold rotate"); // R5

endmodule

// File: rtl/path_hist_folder.sv
module path_hist_folder
  import phc_pkg::*;
#(
  parameter int AW       = 32,
  parameter int BUF_LOG2 = 10,
  parameter int NT       = 4,
  parameter int HLEN  [NT] = '{10, 27, 60, 219},
  parameter int IDX_W [NT] = '{10, 10, 9, 9},
  parameter int TAG_W [NT] = '{9, 11, 13, 13}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          br_valid,
  output logic          br_ready,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] br_tgt,
  input  logic          br_taken,
  input  logic          br_cond,
  output logic          busy,
  output logic [NT*calc_maxw()-1:0] fold_idx,
  output logic [NT*calc_maxw()-1:0] fold_tag,
  output logic [NT*calc_maxw()-1:0] fold_tagm
);

  function automatic int calc_maxw();
    int m = 1;
    for (int t = 0; t < NT; t++) begin
      if (IDX_W[t] > m) m = IDX_W[t];
      if (TAG_W[t] > m) m = TAG_W[t];
    end
    return m;
  endfunction

  localparam int MAXW = calc_maxw();

  logic          step;
  logic          step_bit;
  logic [NT-1:0] aged;

  phc_path_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (br_valid),
    .in_ready (br_ready),
    .pc       (br_pc),
    .tgt      (br_tgt),
    .taken    (br_taken),
    .cond     (br_cond),
    .busy     (busy),
    .step     (step),
    .step_bit (step_bit)
  );

  phc_hist_buf #(.BUF_LOG2(BUF_LOG2), .NT(NT), .HLEN(HLEN)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .new_bit (step_bit),
    .aged_o  (aged)
  );

  for (genvar t = 0; t < NT; t++) begin : g_tbl
    phc_fold_reg #(.L(HLEN[t]), .W(IDX_W[t]), .MAXW(MAXW)) u_idx (
      .clk (clk), .rst (rst), .step (step), .new_bit (step_bit),
      .aged_bit (aged[t]), .val_o (fold_idx[t*MAXW +: MAXW])
    );
    phc_fold_reg #(.L(HLEN[t]), .W(TAG_W[t]), .MAXW(MAXW)) u_tag (
      .clk (clk), .rst (rst), .step (step), .new_bit (step_bit),
      .aged_bit (aged[t]), .val_o (fold_tag[t*MAXW +: MAXW])
    );
    phc_fold_reg #(.L(HLEN[t]), .W(TAG_W[t]-1), .MAXW(MAXW)) u_tagm (
      .clk (clk), .rst (rst), .step (step), .new_bit (step_bit),
      .aged_bit (aged[t]), .val_o (fold_tagm[t*MAXW +: MAXW])
    );
  end

  AST_IDLE_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(fold_idx) && $stable(fold_tag) && $stable(fold_tagm))) else $error("idle hold"); // R9

  AST_READY_MATCH: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_ready) |=> !br_ready) else $error("ready after accept"); // R2

endmodule

// File: tb/sim_path_hist_folder.sv
module sim_path_hist_folder;

  localparam int NT   = 4;
  localparam int AW   = 32;
  localparam int MAXW = 13;
  localparam int BL [NT] = '{10, 27, 60, 219};
  localparam int BI [NT] = '{10, 10, 9, 9};
  localparam int BT [NT] = '{9, 11, 13, 13};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br_valid = 1'b0;
  logic br_ready;
  logic [AW-1:0] br_pc = '0;
  logic [AW-1:0] br_tgt = '0;
  logic br_taken = 1'b0;
  logic br_cond = 1'b0;
  logic busy;
  logic [NT*MAXW-1:0] fold_idx, fold_tag, fold_tagm;

  always #10 clk = ~clk;  // 50 MHz

  path_hist_folder #(.AW(AW), .BUF_LOG2(10), .NT(NT), .HLEN(BL), .IDX_W(BI), .TAG_W(BT)) u0 (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_ready(br_ready),
    .br_pc(br_pc), .br_tgt(br_tgt), .br_taken(br_taken), .br_cond(br_cond),
    .busy(busy), .fold_idx(fold_idx), .fold_tag(fold_tag), .fold_tagm(fold_tagm)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit hist[$];
  logic [NT*MAXW-1:0] q_ix[$], q_tg[$], q_tm[$];
  string q_lb[$];
  logic [NT*MAXW-1:0] last_ix, last_tg, last_tm;
  int done_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [MAXW-1:0] ref_fold(input int L, input int W);
    logic [MAXW-1:0] r = '0;
    for (int k = 0; k < L; k++)
      if (k < hist.size() && hist[k]) r[k % W] = ~r[k % W];
    return r;
  endfunction

  task automatic model_push(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                            input logic tk, input logic cd, input string lbl);
    logic [AW-1:0] mix;
    logic [9:0] p;
    logic [NT*MAXW-1:0] ix, tg, tm;
    mix = tgt ^ (tgt >> 3) ^ pc;
    p = cd ? {9'b0, tk} : mix[9:0];   // R3 / R4
    for (int i = 0; i < 10; i++) hist.push_front(p[i]);
    while (hist.size() > 300) void'(hist.pop_back());
    for (int t = 0; t < NT; t++) begin
      ix[t*MAXW +: MAXW] = ref_fold(BL[t], BI[t]);
      tg[t*MAXW +: MAXW] = ref_fold(BL[t], BT[t]);
      tm[t*MAXW +: MAXW] = ref_fold(BL[t], BT[t]-1);
    end
    q_ix.push_back(ix); q_tg.push_back(tg); q_tm.push_back(tm); q_lb.push_back(lbl);
  endtask

  // Driver
  task automatic send(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                      input logic tk, input logic cd, input string lbl, input bit junk);
    @(negedge clk);
    while (!br_ready) @(negedge clk);
    br_valid = 1'b1; br_pc = pc; br_tgt = tgt; br_taken = tk; br_cond = cd;
    model_push(pc, tgt, tk, cd, lbl);
    @(negedge clk);
    if (junk) begin
      for (int j = 0; j < 5; j++) begin
        chk(br_ready == 1'b0, "R2 ready low while busy", 64'(br_ready), 64'd0);
        br_pc = $urandom; br_tgt = $urandom; br_taken = $urandom; br_cond = $urandom;
        @(negedge clk);
      end
    end
    br_valid = 1'b0;
  endtask

  // Monitor
  initial begin
    bit prev_busy = 0;
    int run = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (busy) run++;
        if (prev_busy && !busy) begin
          chk(run == 10, "R2 busy cycles", 64'(run), 64'd10);
          run = 0;
          if (q_ix.size() == 0) begin
            chk(1'b0, "R2 unexpected result", 64'd0, 64'd0);
          end else begin
            logic [NT*MAXW-1:0] ix, tg, tm;
            string lb;
            ix = q_ix.pop_front(); tg = q_tg.pop_front(); tm = q_tm.pop_front(); lb = q_lb.pop_front();
            for (int t = 0; t < NT; t++) begin
              chk(fold_idx[t*MAXW +: MAXW] == ix[t*MAXW +: MAXW],
                  $sformatf("R5/R10 %s tbl%0d idx", lb, t), 64'(fold_idx[t*MAXW +: MAXW]), 64'(ix[t*MAXW +: MAXW]));
              chk(fold_tag[t*MAXW +: MAXW] == tg[t*MAXW +: MAXW],
                  $sformatf("R6 %s tbl%0d tag", lb, t), 64'(fold_tag[t*MAXW +: MAXW]), 64'(tg[t*MAXW +: MAXW]));
              chk(fold_tagm[t*MAXW +: MAXW] == tm[t*MAXW +: MAXW],
                  $sformatf("R6 %s tbl%0d tagm", lb, t), 64'(fold_tagm[t*MAXW +: MAXW]), 64'(tm[t*MAXW +: MAXW]));
            end
            last_ix = ix; last_tg = tg; last_tm = tm;
          end
          done_cnt++;
        end
        prev_busy = busy;
      end
    end
  end

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int sent = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(fold_idx == '0 && fold_tag == '0 && fold_tagm == '0, "R1 folds zero", 64'(fold_idx), 64'd0);
    chk(br_ready == 1'b1 && busy == 1'b0, "R1 ready/busy", {62'd0, br_ready, busy}, 64'd2);

    // R4: conditional branches
    for (int i = 0; i < 8; i++) begin
      send($urandom, $urandom, (i % 3) != 0, 1'b1, "R4", 1'b0); sent++;
    end
    send(32'h1234_5678, 32'h0000_0040, 1'b0, 1'b0, "R3", 1'b0); sent++;
    send(32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, "R3", 1'b0); sent++;
    // R3 with inputs changed while busy (R2 ignore)
    for (int i = 0; i < 30; i++) begin
      send($urandom, $urandom, 1'b0, 1'b0, "R3", i % 4 == 0); sent++;
    end
    wait_done(sent);
    // R9: idle hold
    repeat (6) @(negedge clk);
    chk(fold_idx == last_ix, "R9 idle idx hold", 64'(fold_idx), 64'(last_ix));
    chk(fold_tag == last_tg && fold_tagm == last_tm, "R9 idle tag hold", 64'(fold_tag), 64'(last_tg));
    // R7 / R8: long mixed run, history exceeds every length and pointer wraps
    for (int i = 0; i < 150; i++) begin
      logic cd;
      cd = ($urandom % 3) == 0;
      send($urandom, $urandom, $urandom, cd, (i < 60) ? "R7" : "R8", i % 17 == 0); sent++;
    end
    // zero branches flush history: values must return to zero (R7)
    for (int i = 0; i < 23; i++) begin
      send(32'h0, 32'h0, 1'b0, 1'b1, "R7", 1'b0); sent++;
    end
    wait_done(sent);
    repeat (2) @(negedge clk);
    chk(fold_idx == '0 && fold_tag == '0 && fold_tagm == '0, "R7 flushed to zero", 64'(fold_tag), 64'd0);
    chk(q_ix.size() == 0, "R2 all results seen", 64'(q_ix.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule